// File: doc/BRIEF.md
# Sleep and Offset Calibration Controller

This controller sits beside the charge and discharge counters of a battery monitor. It decides whether the monitor is counting, asleep, or measuring its own input offset. It watches four things: the level of the host serial line, a comparator flag that says whether the sense signal magnitude exceeds the wake threshold, a once-per-second tick, and two mode bits (calibrate and override). The threshold comparator and the analog front end stay outside the block.

The counters run while `count_en_o` is high. A quiet period stops them: the serial line held low with the signal below threshold for longer than the qualifying time. The block then either sleeps, or, when calibration is requested, runs a one-hour offset measurement. The measurement is an up/down accumulator that starts at zero and steps once per second by the sign of the residual signal. At the end of a clean run, the result is written as an 8-bit two's-complement offset. A one-cycle strobe then tells the mode register to drop its calibrate bit. The block sleeps afterwards until the host raises the line. If the conditions break during a run, the run is discarded and must qualify again from the start.

Top module: `sleep_cal_ctrl`

## Requirements
- R1: After reset, `count_en_o` is 1, `wake_drive_o` is 0, `cal_done_o` is 0 and `ofs_o` is 0.
- R2: `wake_drive_o` is 1 (pull the open-drain wake pin low) exactly when `line_i` is 1 and `above_i` is 1. Otherwise it is 0 (pin released).
- R3: With `cal_en_i` 0, a tick counts as qualified when `line_i` is 0 and `above_i` is 0. Counting stops (`count_en_o` 0, sleep) after LOW_SECS+1 consecutive qualified ticks. Any cycle with `line_i` 1 or `above_i` 1 restarts that count.
- R4: In sleep, ticks have no effect. `line_i` at 1 returns the block to normal operation, and `count_en_o` is 1 after the next clock edge.
- R5: With `cal_en_i` 1, the same qualifier as R3 starts a calibration run instead of sleep. `count_en_o` is 0 during the run.
- R6: A run completes on its CAL_SECS-th tick. On that edge `ofs_o` takes the accumulated value, `cal_done_o` is 1 for exactly one cycle, and the block enters sleep. `ofs_o` changes at no other time.
- R7: A run is aborted by `above_i` at 1, by `cal_en_i` at 0, or by `line_i` at 1 (without override). After an abort the block returns to normal counting, leaves `ofs_o` unchanged and raises no strobe. The next run starts from a zero accumulator and a zero tick count, and only after a fresh R3 qualification.
- R8: With `cal_en_i` and `ovr_i` both 1, a run starts on the edge after `above_i` is 0, whatever `line_i` is. During such a run `line_i` at 1 does not abort.
- R9: Each tick during a run adds +1 when `dir_neg_i` is 0 and adds -1 when `dir_neg_i` is 1. `ofs_o` is two's complement, so bit 7 set means a net discharge-direction offset.
- R10: The accumulator saturates at +127 and -128 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Serial line level |
| above_i | input | 1 | Signal magnitude above wake threshold |
| sec_tick_i | input | 1 | One-cycle pulse per second |
| dir_neg_i | input | 1 | Residual signal in discharge direction |
| cal_en_i | input | 1 | Mode register calibrate bit |
| ovr_i | input | 1 | Mode register line-low override bit |
| wake_drive_o | output | 1 | 1 = pull wake pin low |
| count_en_o | output | 1 | Charge/discharge counting enabled |
| cal_done_o | output | 1 | One-cycle strobe at calibration completion |
| ofs_o | output | 8 | Stored offset, two's complement |

## Verification
A qualifier counter that is off by one shows up at `count_en_o`: it falls one tick early or late against the LOW_SECS+1 tick boundary, so the error is visible on the tick that should or should not have stopped counting. An accumulator or run counter that survives an abort becomes visible only at the end of the next run. It then shows as a wrong `ofs_o` value or as a `cal_done_o` strobe that arrives too early. The bench therefore makes each aborted run leave a distinctive residue before it restarts. A saturation fault appears only in `ofs_o`, one full run later, so the sweep pushes the accumulator past both limits.

// File: rtl/sleep_cal_ctrl.sv
module sleep_cal_ctrl #(
  parameter int LOW_SECS = 10,
  parameter int CAL_SECS = 3600,
  parameter int OFS_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             above_i,
  input  logic             sec_tick_i,
  input  logic             dir_neg_i,
  input  logic             cal_en_i,
  input  logic             ovr_i,
  output logic             wake_drive_o,
  output logic             count_en_o,
  output logic             cal_done_o,
  output logic [OFS_W-1:0] ofs_o
);
  localparam int QW = $clog2(LOW_SECS + 1);
  localparam int CW = $clog2(CAL_SECS + 1);
  localparam logic [OFS_W-1:0] ACC_MAX = {1'b0, {(OFS_W-1){1'b1}}};
  localparam logic [OFS_W-1:0] ACC_MIN = {1'b1, {(OFS_W-1){1'b0}}};

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_CAL} st_t;

  st_t              st_q;
  logic [QW-1:0]    low_q;
  logic [CW-1:0]    run_q;
  logic [OFS_W-1:0] acc_q, acc_step;

  wire quiet  = !line_i && !above_i;
  wire cal_ok = cal_en_i && !above_i && (ovr_i || !line_i);

  assign wake_drive_o = line_i && above_i;
  assign count_en_o   = (st_q == ST_RUN);

  always_comb begin
    acc_step = acc_q;
    if (dir_neg_i) begin
      if (acc_q != ACC_MIN) acc_step = acc_q - OFS_W'(1);
    end else begin
      if (acc_q != ACC_MAX) acc_step = acc_q + OFS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      low_q      <= '0;
      run_q      <= '0;
      acc_q      <= '0;
      ofs_o      <= '0;
      cal_done_o <= 1'b0;
    end else begin
      cal_done_o <= 1'b0;
      case (st_q)
        ST_RUN: begin
          if (cal_en_i && ovr_i && !above_i) begin
            st_q  <= ST_CAL;
            low_q <= '0;
            run_q <= '0;
            acc_q <= '0;
          end else if (!quiet) begin
            low_q <= '0;
          end else if (sec_tick_i) begin
            if (low_q == QW'(LOW_SECS)) begin
              low_q <= '0;
              run_q <= '0;
              acc_q <= '0;
              st_q  <= cal_en_i ? ST_CAL : ST_SLEEP;
            end else begin
              low_q <= low_q + QW'(1);
            end
          end
        end
        ST_SLEEP: begin
          if (line_i) st_q <= ST_RUN;
        end
        ST_CAL: begin
          if (!cal_ok) begin
            st_q <= ST_RUN;
          end else if (sec_tick_i) begin
            acc_q <= acc_step;
            if (run_q == CW'(CAL_SECS - 1)) begin
              ofs_o      <= acc_step;
              cal_done_o <= 1'b1;
              st_q       <= ST_SLEEP;
            end else begin
              run_q <= run_q + CW'(1);
            end
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end
endmodule

module sleep_cal_ctrl_chk #(
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_i,
  input logic             above_i,
  input logic             cal_en_i,
  input logic             count_en_o,
  input logic             cal_done_o,
  input logic [OFS_W-1:0] ofs_o
);
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |=> !cal_done_o);
  a_r6_done_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |-> !count_en_o);
  a_r6_ofs_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ofs_o) |-> cal_done_o);
  a_r3_stop_when_below: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(count_en_o) |-> !$past(above_i));
  a_r4_resume_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_en_o) |-> $past(line_i || above_i || !cal_en_i));
endmodule

bind sleep_cal_ctrl sleep_cal_ctrl_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_i(line_i), .above_i(above_i),
  .cal_en_i(cal_en_i), .count_en_o(count_en_o), .cal_done_o(cal_done_o),
  .ofs_o(ofs_o)
);

// File: tb/sim_sleep_cal_ctrl.sv
module sim_sleep_cal_ctrl;
  localparam int LOWS = 3;
  localparam int CALS = 140;

  logic clk = 0, rst_n = 0, line = 0, above = 0, tick = 0, dneg = 0;
  logic cal_en = 0, ovr = 0;
  logic wake, cnt_en, done;
  logic [7:0] ofs;
  int nchk = 0, nbad = 0;
  bit fin = 0;

  sleep_cal_ctrl #(.LOW_SECS(LOWS), .CAL_SECS(CALS), .OFS_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line), .above_i(above),
    .sec_tick_i(tick), .dir_neg_i(dneg), .cal_en_i(cal_en), .ovr_i(ovr),
    .wake_drive_o(wake), .count_en_o(cnt_en), .cal_done_o(done), .ofs_o(ofs)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(bit neg);
    tick = 1; dneg = neg;
    @(negedge clk);
    tick = 0; dneg = 0;
  endtask

  function automatic int sat(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic qualify();
    line = 0; above = 0;
    repeat (LOWS + 1) pulse(0);
  endtask

  task automatic cal_run(int k, int start, string tag);
    int m = start;
    for (int i = 0; i < CALS; i++) begin
      bit neg = (i < k);
      m = sat(m + (neg ? -1 : 1));
      pulse(neg);
      if (i == CALS - 2) chk({tag, " R6 no strobe before last tick"}, done, 0);
    end
    chk({tag, " R6 strobe on last tick"}, done, 1);
    chk({tag, " R9 R10 offset value"}, int'($signed(ofs)), m);
    chk({tag, " R9 sign bit means discharge"}, ofs[7], (m < 0) ? 1 : 0);
    chk({tag, " R6 sleep after run"}, cnt_en, 0);
    cal_en = 0;
    step();
    chk({tag, " R6 strobe is one cycle"}, done, 0);
  endtask

  initial begin
    #2_000_000;
    if (!fin) begin
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int saved;
    repeat (3) step();
    chk("R1 count enable in reset", cnt_en, 1);
    chk("R1 wake released", wake, 0);
    chk("R1 strobe low", done, 0);
    chk("R1 offset zero", ofs, 0);
    rst_n = 1;
    step();

    for (int c = 0; c < 4; c++) begin
      line = c[0]; above = c[1];
      step();
      chk("R2 wake drive", wake, c[0] & c[1]);
      chk("R2 no state change", cnt_en, 1);
    end

    line = 0; above = 0;
    repeat (LOWS) pulse(0);
    chk("R3 still counting at LOW_SECS ticks", cnt_en, 1);
    line = 1; step(); line = 0;
    repeat (LOWS) pulse(0);
    chk("R3 line break restarts qualifier", cnt_en, 1);
    above = 1; step(); above = 0;
    repeat (LOWS) pulse(0);
    chk("R3 threshold break restarts qualifier", cnt_en, 1);
    pulse(0);
    chk("R3 sleep after LOW_SECS+1 ticks", cnt_en, 0);
    repeat (5) pulse(1);
    chk("R4 ticks ignored in sleep", cnt_en, 0);
    chk("R4 offset untouched in sleep", ofs, 0);
    line = 1; step();
    chk("R4 line high resumes counting", cnt_en, 1);

    for (int j = 0; j < 6; j++) begin
      int ks[6] = '{0, 140, 70, 3, 139, 100};
      cal_en = 1;
      qualify();
      chk("R5 calibration entered", cnt_en, 0);
      cal_run(ks[j], 0, "sweep");
      line = 1; step();
      chk("R4 resume after calibration", cnt_en, 1);
    end

    saved = int'($signed(ofs));
    cal_en = 1;
    qualify();
    repeat (20) pulse(1);
    above = 1; step();
    chk("R7 threshold aborts run", cnt_en, 1);
    chk("R7 offset kept after abort", int'($signed(ofs)), saved);
    chk("R7 no strobe on abort", done, 0);
    above = 0;
    repeat (LOWS) pulse(0);
    chk("R7 restart needs full qualifier", cnt_en, 1);
    pulse(0);
    chk("R7 restarted run", cnt_en, 0);
    repeat (10) pulse(1);
    line = 1; step();
    chk("R7 line high aborts run", cnt_en, 1);
    qualify();
    repeat (7) pulse(1);
    cal_en = 0; step();
    chk("R7 calibrate bit clear aborts run", cnt_en, 1);
    cal_en = 1;
    qualify();
    cal_run(70, 0, "R7 accumulator cleared");
    line = 1; step();

    ovr = 1; cal_en = 1; line = 1; above = 1;
    step();
    chk("R8 no start while above threshold", cnt_en, 1);
    above = 0; step();
    chk("R8 override starts run with line high", cnt_en, 0);
    line = 0; step(); line = 1; step();
    chk("R8 line toggle does not abort", cnt_en, 0);
    cal_run(30, 0, "R8 override run");
    ovr = 0;
    step();
    chk("R4 line high leaves post-run sleep", cnt_en, 1);

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule